// File: doc/BRIEF.md
# Transport Packet Output Formatter

This block sits between a decoded-packet source and a parallel transport-stream consumer. It collects one 188-byte transport packet at a time from a byte-wide valid/ready input, along with a flag that marks the packet as uncorrectable. Once the whole packet is held locally, it plays the packet out on 188 back-to-back output clock cycles. Next to the byte bus it drives three strobes: a start pulse on the first byte, a valid level over all bytes, and an active-low error level over the packets marked uncorrectable.

Per-packet controls are taken when a packet starts playing out. They set whether the transport error indicator (most significant bit of header byte 1, the byte after the 0x47 sync byte) is forced high for uncorrectable packets, whether the bus bit order is mirrored, and whether the output is silenced. A live polarity input chooses the output launch edge. With it high, every output moves on the falling clock edge, so it is settled at the next rising edge. With it low, outputs move on the rising edge.

The controller has three states. ST_FILL accepts input bytes. It moves to ST_SEND when byte 187 is accepted (transition "packet loaded"). ST_SEND plays out bytes 0 to 187 and moves to ST_REST after byte 187 (transition "packet sent"). ST_REST holds for GAP_LEN cycles and then returns to ST_FILL (transition "rest over"). Reset enters ST_FILL.

Top module: `tsout_fmt`

## Requirements
- R1: Each packet leaves on 188 consecutive output cycles, in the byte order it was accepted.
- R2: out_data is all zeros whenever out_valid is low.
- R3: out_start is high only with the first byte (index 0) of each packet.
- R4: out_valid rises with byte 0, stays high for exactly 188 cycles, then falls.
- R5: out_err_n is low for all 188 bytes of a packet whose in_bad was 1 on its byte 0. It is high for other packets and between packets.
- R6: With tei_en=1 and the packet flagged bad, bit 7 of byte index 1 is forced to 1 before any mirroring.
- R7: With tei_en=0, or with a good packet, every byte passes unchanged, so an incoming 1 in bit 7 of byte 1 stays 1.
- R8: With clk_inv=1, outputs change on the falling clock edge. With clk_inv=0, they change on the rising edge.
- R9: With swap_bits=1, output bit i carries formatted bit 7-i.
- R10: With oe_n=1 when a packet starts playing out, that packet is consumed and all outputs stay idle (data 0, start 0, valid 0, err_n 1).
- R11: in_ready is high only in ST_FILL. Playout begins only after all 188 bytes are accepted, and in_ready is low during playout.
- R12: tei_en, swap_bits and oe_n are sampled once, when the last input byte is accepted. At least GAP_LEN idle output cycles separate two packets.
- R13: After reset, outputs are idle and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Formatter can take an input byte |
| in_data | input | 8 | Input packet byte |
| in_bad | input | 1 | Uncorrectable flag, taken with byte 0 |
| tei_en | input | 1 | Force error indicator on bad packets |
| swap_bits | input | 1 | Mirror output bit order |
| clk_inv | input | 1 | 1: launch on falling edge; 0: rising edge |
| oe_n | input | 1 | Active-low output enable |
| out_data | output | 8 | Output byte bus |
| out_start | output | 1 | First-byte strobe |
| out_valid | output | 1 | Packet byte valid |
| out_err_n | output | 1 | Active-low uncorrectable-packet strobe |

## Verification
A bad read or fill index shows up at once as a byte mismatch against the model of the accepted packet, on the first affected output cycle. A wrong state or a miscounting playout counter shows up as a valid run that is not 188 long, a missing or repeated start pulse, or in_ready rising while valid is still high, all within one packet time. A wrong latched flag or control shows up as a wrong error level or header bit from byte 0 or byte 1. A wrong launch edge shows up within half a clock of the first byte.

// File: rtl/tsout_pkg.sv
package tsout_pkg;

    localparam int BYTE_W   = 8;
    localparam int TEI_BYTE = 1;
    localparam int TEI_BIT  = 7;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_SEND = 2'd1,
        ST_REST = 2'd2
    } tsout_state_e;

    typedef struct packed {
        logic tei_en;
        logic swap;
        logic quiet;
    } tsout_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              start;
        logic              valid;
        logic              err_n;
    } tsout_lane_t;

    localparam tsout_lane_t LANE_IDLE = '{data: '0, start: 1'b0, valid: 1'b0, err_n: 1'b1};

endpackage

// File: rtl/tsout_store.sv
module tsout_store #(
    parameter int DEPTH = 188,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/tsout_ctrl.sv
module tsout_ctrl
    import tsout_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int GAP_LEN = 4,
    localparam int AW     = $clog2(PKT_LEN),
    localparam int RW     = $clog2(GAP_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_bad,
    input  logic          tei_en,
    input  logic          swap_bits,
    input  logic          oe_n,
    output logic          in_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [AW-1:0] rd_idx,
    output logic          sending,
    output logic          first_byte,
    output logic          tei_slot,
    output logic          pkt_bad,
    output tsout_cfg_t    pkt_cfg
);

    tsout_state_e state_q, state_d;
    logic [RW-1:0] rest_cnt;
    logic wr_last, rd_last, rest_done;

    assign wr_last   = (wr_idx == AW'(PKT_LEN - 1));
    assign rd_last   = (rd_idx == AW'(PKT_LEN - 1));
    assign rest_done = (rest_cnt == RW'(GAP_LEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: packet loaded, packet sent, rest over
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (wr_en && wr_last) state_d = ST_SEND;
            ST_SEND: if (rd_last)          state_d = ST_REST;
            ST_REST: if (rest_done)        state_d = ST_FILL;
            default:                       state_d = ST_FILL;
        endcase
    end

    // state outputs
    always_comb begin
        in_ready = 1'b0;
        sending  = 1'b0;
        unique case (state_q)
            ST_FILL: in_ready = 1'b1;
            ST_SEND: sending  = 1'b1;
            ST_REST: ;
            default: ;
        endcase
    end

    assign wr_en      = in_valid && in_ready;
    assign first_byte = sending && (rd_idx == '0);
    assign tei_slot   = sending && (rd_idx == AW'(TEI_BYTE));

    // indices, per-packet flag and sampled controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            rest_cnt <= '0;
            pkt_bad  <= 1'b0;
            pkt_cfg  <= '{tei_en: 1'b1, swap: 1'b0, quiet: 1'b0};
        end else begin
            unique case (state_q)
                ST_FILL: begin
                    if (wr_en) begin
                        wr_idx <= wr_last ? '0 : wr_idx + 1'b1;
                        if (wr_idx == '0) begin
                            pkt_bad <= in_bad;
                        end
                        if (wr_last) begin
                            pkt_cfg <= '{tei_en: tei_en, swap: swap_bits, quiet: oe_n};
                            rd_idx  <= '0;
                        end
                    end
                end
                ST_SEND: begin
                    rd_idx <= rd_last ? '0 : rd_idx + 1'b1;
                    if (rd_last) begin
                        rest_cnt <= '0;
                    end
                end
                ST_REST: begin
                    rest_cnt <= rest_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tsout_shape.sv
module tsout_shape
    import tsout_pkg::*;
(
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic              sending,
    input  logic              first_byte,
    input  logic              tei_slot,
    input  logic              pkt_bad,
    input  tsout_cfg_t        pkt_cfg,
    output tsout_lane_t       lane_nxt
);

    logic              active;
    logic [BYTE_W-1:0] marked;
    logic [BYTE_W-1:0] mirrored;

    assign active = sending && !pkt_cfg.quiet;

    always_comb begin
        marked = rd_byte;
        if (tei_slot && pkt_bad && pkt_cfg.tei_en) begin
            marked[TEI_BIT] = 1'b1;
        end
    end

    for (genvar b = 0; b < BYTE_W; b++) begin : g_mirror
        assign mirrored[b] = marked[BYTE_W-1-b];
    end

    always_comb begin
        lane_nxt       = LANE_IDLE;
        lane_nxt.data  = active ? (pkt_cfg.swap ? mirrored : marked) : '0;
        lane_nxt.start = active && first_byte;
        lane_nxt.valid = active;
        lane_nxt.err_n = !(active && pkt_bad);
    end

endmodule

// File: rtl/tsout_launch.sv
module tsout_launch
    import tsout_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_inv,
    input  tsout_lane_t lane_nxt,
    output tsout_lane_t lane_out
);

    tsout_lane_t rise_q, fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= LANE_IDLE;
        end else begin
            rise_q <= lane_nxt;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= LANE_IDLE;
        end else begin
            fall_q <= rise_q;
        end
    end

    assign lane_out = clk_inv ? fall_q : rise_q;

endmodule

// File: rtl/tsout_fmt.sv
module tsout_fmt
    import tsout_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int GAP_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    input  logic        in_bad,
    input  logic        tei_en,
    input  logic        swap_bits,
    input  logic        clk_inv,
    input  logic        oe_n,
    output logic [7:0]  out_data,
    output logic        out_start,
    output logic        out_valid,
    output logic        out_err_n
);

    localparam int AW = $clog2(PKT_LEN);

    logic          wr_en, sending, first_byte, tei_slot, pkt_bad;
    logic [AW-1:0] wr_idx, rd_idx;
    logic [BYTE_W-1:0] rd_byte;
    tsout_cfg_t    pkt_cfg;
    tsout_lane_t   lane_nxt, lane_out;

    tsout_ctrl #(.PKT_LEN(PKT_LEN), .GAP_LEN(GAP_LEN)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bad    (in_bad),
        .tei_en    (tei_en),
        .swap_bits (swap_bits),
        .oe_n      (oe_n),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .sending   (sending),
        .first_byte(first_byte),
        .tei_slot  (tei_slot),
        .pkt_bad   (pkt_bad),
        .pkt_cfg   (pkt_cfg)
    );

    tsout_store #(.DEPTH(PKT_LEN), .W(BYTE_W)) store_i (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(in_data),
        .rd_idx (rd_idx),
        .rd_data(rd_byte)
    );

    tsout_shape shape_i (
        .rd_byte   (rd_byte),
        .sending   (sending),
        .first_byte(first_byte),
        .tei_slot  (tei_slot),
        .pkt_bad   (pkt_bad),
        .pkt_cfg   (pkt_cfg),
        .lane_nxt  (lane_nxt)
    );

    tsout_launch launch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_inv (clk_inv),
        .lane_nxt(lane_nxt),
        .lane_out(lane_out)
    );

    assign out_data  = lane_out.data;
    assign out_start = lane_out.start;
    assign out_valid = lane_out.valid;
    assign out_err_n = lane_out.err_n;

endmodule

// File: rtl/tsout_fmt_chk.sv
module tsout_fmt_chk #(
    parameter int PKT_LEN = 188
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [7:0] out_data,
    input logic       out_start,
    input logic       out_valid,
    input logic       out_err_n
);

    localparam int CW = $clog2(PKT_LEN + 2);
    logic [CW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (out_valid) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R3
    start_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> out_valid);

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |=> !out_start);

    // R4
    valid_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_start);

    // R4
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> run_len == CW'(PKT_LEN));

    // R2
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_data == 8'h00);

    // R5
    err_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_err_n |-> out_valid);

    // R5
    err_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_start) |-> $stable(out_err_n));

    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

endmodule

bind tsout_fmt tsout_fmt_chk #(.PKT_LEN(PKT_LEN)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_start(out_start),
    .out_valid(out_valid),
    .out_err_n(out_err_n)
);

// File: tb/tsout_fmt_tb_top.sv
module tsout_fmt_tb_top;

    localparam int PKT = 188;
    localparam int GAP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_bad = 1'b0;
    logic       tei_en = 1'b1;
    logic       swap_bits = 1'b0;
    logic       clk_inv = 1'b1;
    logic       oe_n = 1'b0;
    logic [7:0] out_data;
    logic       out_start, out_valid, out_err_n;

    always #2 clk = ~clk;

    tsout_fmt #(.PKT_LEN(PKT), .GAP_LEN(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_bad(in_bad), .tei_en(tei_en), .swap_bits(swap_bits),
        .clk_inv(clk_inv), .oe_n(oe_n), .out_data(out_data), .out_start(out_start),
        .out_valid(out_valid), .out_err_n(out_err_n)
    );

    int total = 0;
    int bad = 0;
    int exp_pkts = 0;
    int seen_pkts = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    bit         exp_bad_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fmt(input logic [7:0] b, input int i,
                                       input bit pbad, input bit tei, input bit sw);
        logic [7:0] v;
        logic [7:0] r;
        v = b;
        if (i == 1 && pbad && tei) v[7] = 1'b1;
        for (int k = 0; k < 8; k++) r[k] = v[7-k];
        return sw ? r : v;
    endfunction

    // output monitor: early sample 1 ns after rising edge, late sample 3 ns after
    int  cnt = 0;
    int  gap_run = 0;
    bit  any_seen = 1'b0;
    bit  cur_bad = 1'b0;
    logic early_start;
    always begin
        @(posedge clk);
        if (mon_on) begin
            #1 early_start = out_start;
            #2;
            if (out_valid) begin
                if (cnt == 0) begin
                    if (any_seen) chk(gap_run >= GAP, "R12 idle gap", gap_run, GAP);
                    chk(out_start === 1'b1, "R3 start on byte 0", out_start, 1);
                    // R8: falling-edge launch hides the new value 1 ns after the rising edge
                    chk(early_start === !clk_inv, "R8 launch edge", early_start, !clk_inv);
                    if (exp_bad_q.size() == 0) begin
                        chk(1'b0, "R10 unexpected packet", 1, 0);
                        cur_bad = 1'b0;
                    end else begin
                        cur_bad = exp_bad_q.pop_front();
                    end
                end else begin
                    chk(out_start === 1'b0, "R3 start after byte 0", out_start, 0);
                end
                if (exp_q.size() != 0) begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(out_data === e, (cnt == 1) ? "R6 R7 header byte" : "R1 R9 data byte",
                        out_data, e);
                end
                chk(out_err_n === !cur_bad, "R5 error strobe", out_err_n, !cur_bad);
                chk(in_ready === 1'b0, "R11 ready low in playout", in_ready, 0);
                cnt++;
                gap_run = 0;
            end else begin
                if (cnt != 0) begin
                    chk(cnt == PKT, "R4 valid run length", cnt, PKT);
                    seen_pkts++;
                    any_seen = 1'b1;
                end
                cnt = 0;
                gap_run++;
                chk(out_data === 8'h00, "R2 idle bus", out_data, 0);
                chk(out_start === 1'b0 && out_err_n === 1'b1, "R5 idle strobes",
                    {out_start, out_err_n}, 1);
            end
        end
    end

    task automatic send_pkt(input bit pbad, input bit tei, input bit sw, input bit inv,
                            input bit quiet, input logic [7:0] hdr1);
        logic [7:0] pk[PKT];
        int idx;
        bit hs;
        do @(negedge clk); while (!in_ready);
        tei_en = tei; swap_bits = sw; clk_inv = inv; oe_n = quiet;
        pk[0] = 8'h47;
        pk[1] = hdr1;
        for (int i = 2; i < PKT; i++) pk[i] = 8'($urandom);
        if (!quiet) begin
            for (int i = 0; i < PKT; i++) exp_q.push_back(fmt(pk[i], i, pbad, tei, sw));
            exp_bad_q.push_back(pbad);
            exp_pkts++;
        end
        idx = 0;
        while (idx < PKT) begin
            in_valid = ($urandom % 4) != 0;
            in_data  = in_valid ? pk[idx] : 8'($urandom);
            in_bad   = (idx == 0) ? pbad : 1'($urandom);
            hs = in_valid && in_ready;
            @(posedge clk);
            if (hs) idx++;
            @(negedge clk);
        end
        // R12: controls moved during playout must not affect this packet
        tei_en = 1'($urandom); swap_bits = 1'($urandom); oe_n = 1'($urandom);
        // R11: input offered during playout is ignored
        in_valid = 1'b1; in_data = 8'hA5; in_bad = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13
        chk(in_ready === 1'b1, "R13 ready after reset", in_ready, 1);
        chk(out_valid === 1'b0 && out_start === 1'b0, "R13 strobes after reset",
            {out_valid, out_start}, 0);
        chk(out_err_n === 1'b1, "R13 err_n after reset", out_err_n, 1);
        chk(out_data === 8'h00, "R13 data after reset", out_data, 0);
        mon_on = 1'b1;
        // directed corner cases
        send_pkt(0, 1, 0, 0, 0, 8'h1F);   // R7 good packet unchanged
        send_pkt(1, 1, 0, 0, 0, 8'h1F);   // R6 forced indicator
        send_pkt(1, 0, 0, 0, 0, 8'h1F);   // R7 disabled, stays 0
        send_pkt(1, 0, 0, 1, 0, 8'h9F);   // R7 incoming 1 stays 1
        send_pkt(0, 1, 0, 1, 0, 8'h9F);   // R7 good with bit set
        send_pkt(1, 1, 1, 1, 0, 8'h12);   // R9 mirrored after forcing
        send_pkt(1, 1, 0, 1, 1, 8'h12);   // R10 silenced packet
        send_pkt(0, 1, 1, 0, 0, 8'h34);
        // random mix
        for (int n = 0; n < 14; n++) begin
            send_pkt(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom % 5) == 0, 8'($urandom));
        end
        do @(negedge clk); while (!in_ready);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        // R10
        chk(seen_pkts == exp_pkts, "R10 packet count", seen_pkts, exp_pkts);
        chk(exp_q.size() == 0, "R1 all bytes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule